// File: doc/BRIEF.md
# Preloadable Interval Timer with Read-Triggered Control

This block is one 16-bit down-counting interval timer on a byte-wide register bus. Software builds the 16-bit preset from two byte writes. A write to the upper-byte register replaces the whole preset with that byte in the top half and zeros in the bottom half. A later write to the lower-byte register ORs its byte into the bottom half. Both halves read back through the same two registers.

The timer has no control bits. Software starts it by reading one address and halts it by reading another, and both reads return zero. A run lasts a fixed number of clock cycles per step, set by a parameter, times the preset, and a preset of zero counts as one step. When the run ends, the block raises a ready flag that the shared interrupt logic samples, and it stays idle until the next start. A halt read also sends a one-cycle pulse that withdraws the pending shared serial interrupt request.

Register map (2-bit address): 0 is the upper preset byte, 1 is the lower preset byte, 2 is start (read), 3 is halt (read).

Top module: `preset_timer`

## Requirements
- R1: After reset the preset is 0x0000, and `tmr_ready`, `tmr_running` and `irq_clr` are all low.
- R2: A selected write to address 0 sets the preset to {wdata, 8'h00}, which clears the lower byte.
- R3: A selected write to address 1 ORs wdata into the lower preset byte and leaves the upper byte unchanged.
- R4: A selected read of address 0 returns the upper preset byte on `bus_rdata` in the same cycle, and a read of address 1 returns the lower byte.
- R5: A selected read of address 2 returns 0x00. In the cycle after its clock edge, `tmr_running` is high and `tmr_ready` is low.
- R6: With preset P and step STEP, `tmr_ready` rises and `tmr_running` falls exactly max(P,1)*STEP clock edges after the start edge.
- R7: Once set, `tmr_ready` stays high and `tmr_running` stays low until a start or halt read.
- R8: A selected read of address 3 returns 0x00. After its edge, `tmr_running` and `tmr_ready` are low, `irq_clr` is high for exactly one cycle, and no expiry follows.
- R9: A start read while a run is in progress reloads the preset, so the expiry comes max(P,1)*STEP edges after the latest start.
- R10: Writes to address 2 or 3, unselected bus cycles, and preset writes during a run do not start, halt or re-time the countdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the access cycle |
| tmr_ready | output | 1 | Expiry flag to the shared interrupt logic |
| tmr_running | output | 1 | Countdown in progress |
| irq_clr | output | 1 | One-cycle pulse after a halt read |

## Verification
A corrupted preset register appears at once on the next readback of either byte, and it also moves the expiry to a different cycle. A fault in the prescaler or the step counter cannot be seen while the timer runs. It only shows up as `tmr_ready` rising early or late, so every run is timed to the exact edge against max(P,1)*STEP. A start/halt decode that fires on writes or unselected cycles appears within one cycle as a change on `tmr_running` or `irq_clr`.

// File: rtl/preset_timer_pkg.sv
// Shared types for the preset timer.
// Assumes a 2-bit register address space with four registers.
package preset_timer_pkg;

    typedef enum logic [1:0] {
        REG_PRESET_HI = 2'd0,
        REG_PRESET_LO = 2'd1,
        REG_GO        = 2'd2,
        REG_HALT      = 2'd3
    } tmr_reg_e;

    // Decoded one-cycle bus strobes
    typedef struct packed {
        logic wr_hi;
        logic wr_lo;
        logic rd_go;
        logic rd_halt;
    } tmr_strobe_t;

endpackage

// File: rtl/tmr_decode.sv
// Bus decoder: turns a selected access into one-cycle strobes.
// Assumes at most one access per cycle and combinational use of the strobes.
module tmr_decode
    import preset_timer_pkg::*;
(
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [1:0]  bus_addr,
    output tmr_strobe_t strobe
);

    // Decode address and direction into strobes
    always_comb begin
        strobe         = '0;
        strobe.wr_hi   = bus_sel &&  bus_wr && (bus_addr == REG_PRESET_HI);
        strobe.wr_lo   = bus_sel &&  bus_wr && (bus_addr == REG_PRESET_LO);
        strobe.rd_go   = bus_sel && !bus_wr && (bus_addr == REG_GO);
        strobe.rd_halt = bus_sel && !bus_wr && (bus_addr == REG_HALT);
    end

endmodule

// File: rtl/tmr_preset.sv
// Preset register and read-data multiplexer.
// The upper-byte write replaces the whole preset and the lower-byte write ORs.
// Assumes CNT_W == 2*DATA_W.
module tmr_preset
    import preset_timer_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  tmr_strobe_t       strobe,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    output logic [CNT_W-1:0]  preset,
    output logic [DATA_W-1:0] bus_rdata
);

    // Preset update from byte writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            preset <= '0;
        end else if (strobe.wr_hi) begin
            preset <= {bus_wdata, {DATA_W{1'b0}}};
        end else if (strobe.wr_lo) begin
            preset <= preset | {{DATA_W{1'b0}}, bus_wdata};
        end
    end

    // Read-back multiplexer; control addresses read as zero
    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            case (bus_addr)
                REG_PRESET_HI: bus_rdata = preset[CNT_W-1:DATA_W];
                REG_PRESET_LO: bus_rdata = preset[DATA_W-1:0];
                default:       bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/tmr_countdown.sv
// Prescaled down-counter with expiry flag and halt acknowledge pulse.
// A run lasts max(preset,1)*STEP cycles from the start edge.
// Start takes priority over halt and over expiry in the same cycle.
module tmr_countdown
    import preset_timer_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int STEP  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  tmr_strobe_t      strobe,
    input  logic [CNT_W-1:0] preset,
    output logic             tmr_ready,
    output logic             tmr_running,
    output logic             irq_clr
);

    localparam int PW = (STEP > 1) ? $clog2(STEP) : 1;
    localparam logic [PW-1:0] PRESC_TOP = PW'(STEP - 1);

    logic [CNT_W-1:0] steps_left;
    logic             step_tick;
    logic [CNT_W-1:0] load_val;

    assign load_val = (preset == '0) ? CNT_W'(1) : preset;

    generate
        if (STEP > 1) begin : g_presc
            logic [PW-1:0] presc;
            // Prescaler: restarts on a start read and wraps every STEP cycles
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    presc <= '0;
                end else if (strobe.rd_go) begin
                    presc <= PRESC_TOP;
                end else if (tmr_running) begin
                    presc <= (presc == '0) ? PRESC_TOP : presc - 1'b1;
                end
            end
            assign step_tick = tmr_running && (presc == '0);
        end else begin : g_nopresc
            assign step_tick = tmr_running;
        end
    endgenerate

    // Step counter, running state and expiry flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            steps_left  <= '0;
            tmr_running <= 1'b0;
            tmr_ready   <= 1'b0;
        end else if (strobe.rd_go) begin
            steps_left  <= load_val;
            tmr_running <= 1'b1;
            tmr_ready   <= 1'b0;
        end else if (strobe.rd_halt) begin
            tmr_running <= 1'b0;
            tmr_ready   <= 1'b0;
        end else if (step_tick) begin
            if (steps_left == CNT_W'(1)) begin
                tmr_running <= 1'b0;
                tmr_ready   <= 1'b1;
            end
            steps_left <= steps_left - 1'b1;
        end
    end

    // One-cycle pulse that withdraws the shared interrupt request
    always_ff @(posedge clk) begin
        if (!rst_n) irq_clr <= 1'b0;
        else        irq_clr <= strobe.rd_halt;
    end

endmodule

// File: rtl/preset_timer.sv
// Top level: a 16-bit preloadable interval timer on a byte register bus.
// Start and halt are side effects of reads. Assumes a synchronous bus
// with one access per cycle.
module preset_timer
    import preset_timer_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int STEP   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              tmr_ready,
    output logic              tmr_running,
    output logic              irq_clr
);

    localparam int CNT_W = 2 * DATA_W;

    tmr_strobe_t      strobe;
    logic [CNT_W-1:0] preset;

    tmr_decode u_decode (
        .bus_sel  (bus_sel),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .strobe   (strobe)
    );

    tmr_preset #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_preset (
        .clk       (clk),
        .rst_n     (rst_n),
        .strobe    (strobe),
        .bus_wdata (bus_wdata),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .preset    (preset),
        .bus_rdata (bus_rdata)
    );

    tmr_countdown #(.CNT_W(CNT_W), .STEP(STEP)) u_count (
        .clk         (clk),
        .rst_n       (rst_n),
        .strobe      (strobe),
        .preset      (preset),
        .tmr_ready   (tmr_ready),
        .tmr_running (tmr_running),
        .irq_clr     (irq_clr)
    );

endmodule

// File: rtl/preset_timer_chk.sv
// Port-level protocol checks for preset_timer, attached by bind.
module preset_timer_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [1:0]        bus_addr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              tmr_ready,
    input logic              tmr_running,
    input logic              irq_clr
);

    logic go_rd, halt_rd;
    assign go_rd   = bus_sel && !bus_wr && (bus_addr == 2'd2);
    assign halt_rd = bus_sel && !bus_wr && (bus_addr == 2'd3);

    // R5
    go_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go_rd |=> (tmr_running && !tmr_ready));

    // R8
    halt_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt_rd && !go_rd |=> (!tmr_running && !tmr_ready && irq_clr));

    // R8
    clr_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !halt_rd |=> !irq_clr);

    // R6
    expiry_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_running && !go_rd && !halt_rd |=> (tmr_running || tmr_ready));

    // R7
    ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_ready && !go_rd && !halt_rd |=> (tmr_ready && !tmr_running));

    // R6
    exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(tmr_ready && tmr_running));

    // R5
    ctrl_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (go_rd || halt_rd) |-> (bus_rdata == '0));

endmodule

bind preset_timer preset_timer_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_sel     (bus_sel),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_rdata   (bus_rdata),
    .tmr_ready   (tmr_ready),
    .tmr_running (tmr_running),
    .irq_clr     (irq_clr)
);

// File: tb/preset_timer_bench.sv
// Scoreboard bench: the read task queues expected bytes and a monitor
// pops and compares them at the falling edge of each read cycle.
module preset_timer_bench;

    localparam int STEP = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       tmr_ready, tmr_running, irq_clr;

    int n_checks = 0;
    int n_fails  = 0;
    int cyc      = 0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    preset_timer #(.DATA_W(8), .STEP(STEP)) u_preset_timer (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tmr_ready(tmr_ready), .tmr_running(tmr_running), .irq_clr(irq_clr)
    );

    task automatic chk(input string tag, input int act, input int expv);
        n_checks++;
        if (act != expv) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
        end
    endtask

    // Monitor: compare read data against the scoreboard
    always @(negedge clk) begin
        if (bus_sel && !bus_wr) begin
            if (exp_q.size() == 0) begin
                chk("scoreboard empty", 0, 1);
            end else begin
                chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
            end
        end
    end

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, input logic [7:0] expv,
                            input string tag);
        @(posedge clk); #1;
        exp_q.push_back(expv); tag_q.push_back(tag);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(posedge clk); #1;
        bus_sel = 1'b0;
    endtask

    task automatic set_preset(input logic [15:0] p);
        bus_write(2'd0, p[15:8]);
        bus_write(2'd1, p[7:0]);
    endtask

    // Waits for ready, returning edges elapsed since t0
    task automatic wait_ready(input int t0, output int dt);
        for (int i = 0; i < 5000 && !tmr_ready; i++) begin
            @(posedge clk); #1;
        end
        dt = cyc - t0;
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        int t0, dt;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        chk("R1 ready", tmr_ready, 0);
        chk("R1 running", tmr_running, 0);
        chk("R1 irq_clr", irq_clr, 0);
        bus_read(2'd0, 8'h00, "R1 preset hi");
        bus_read(2'd1, 8'h00, "R1 preset lo");
        // R2 / R3 / R4 byte loading
        bus_write(2'd0, 8'h12);
        bus_read(2'd0, 8'h12, "R2 hi after write");
        bus_read(2'd1, 8'h00, "R2 lo cleared");
        bus_write(2'd1, 8'h34);
        bus_read(2'd1, 8'h34, "R3 lo load");
        bus_write(2'd1, 8'h41);
        bus_read(2'd1, 8'h75, "R3 lo OR");
        bus_read(2'd0, 8'h12, "R4 hi kept");
        bus_write(2'd0, 8'hAB);
        bus_read(2'd0, 8'hAB, "R4 hi readback");
        bus_read(2'd1, 8'h00, "R2 hi write clears lo");

        // R5 / R6 basic run
        set_preset(16'h0005);
        bus_read(2'd2, 8'h00, "R5 start reads zero");
        t0 = cyc;
        chk("R5 running after start", tmr_running, 1);
        chk("R5 ready low after start", tmr_ready, 0);
        wait_ready(t0, dt);
        chk("R6 expiry P=5", dt, 5 * STEP);
        chk("R6 running low at expiry", tmr_running, 0);
        // R7 hold
        repeat (10) @(posedge clk); #1;
        chk("R7 ready held", tmr_ready, 1);
        chk("R7 stays idle", tmr_running, 0);

        // R6 preset zero, R5 start clears ready
        set_preset(16'h0000);
        bus_read(2'd2, 8'h00, "R5 start zero");
        t0 = cyc;
        chk("R5 start clears ready", tmr_ready, 0);
        wait_ready(t0, dt);
        chk("R6 expiry P=0", dt, STEP);

        // R8 halt mid-run
        set_preset(16'h0003);
        bus_read(2'd2, 8'h00, "R5 start");
        repeat (5) @(posedge clk);
        bus_read(2'd3, 8'h00, "R8 halt reads zero");
        chk("R8 running low", tmr_running, 0);
        chk("R8 irq_clr pulse", irq_clr, 1);
        @(posedge clk); #1;
        chk("R8 irq_clr one cycle", irq_clr, 0);
        repeat (30) @(posedge clk); #1;
        chk("R8 no expiry after halt", tmr_ready, 0);

        // R8 halt clears ready
        bus_read(2'd2, 8'h00, "R5 start");
        t0 = cyc;
        wait_ready(t0, dt);
        chk("R6 expiry P=3", dt, 3 * STEP);
        bus_read(2'd3, 8'h00, "R8 halt");
        chk("R8 halt clears ready", tmr_ready, 0);

        // R9 restart
        set_preset(16'h0004);
        bus_read(2'd2, 8'h00, "R9 first start");
        repeat (10) @(posedge clk);
        bus_read(2'd2, 8'h00, "R9 restart");
        t0 = cyc;
        wait_ready(t0, dt);
        chk("R9 expiry from restart", dt, 4 * STEP);

        // R10 ignored accesses
        bus_write(2'd3, 8'hFF);
        bus_write(2'd2, 8'hFF);
        chk("R10 write to start ignored", tmr_running, 0);
        chk("R10 write to halt keeps ready", tmr_ready, 1);
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = 2'd2;
        @(posedge clk); #1;
        chk("R10 unselected no start", tmr_running, 0);
        set_preset(16'h0006);
        bus_read(2'd2, 8'h00, "R10 start");
        t0 = cyc;
        bus_write(2'd3, 8'h00);
        set_preset(16'h0001);
        chk("R10 running after ctrl writes", tmr_running, 1);
        wait_ready(t0, dt);
        chk("R10 expiry not re-timed", dt, 6 * STEP);
        bus_read(2'd1, 8'h01, "R10 preset updated during run");

        repeat (2) @(posedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule